// File: doc/BRIEF.md
# Condition Register Logic Unit

This block keeps a 32-bit condition register and updates it by at most one operation per clock. A bit operation reads two single bits of the register, picks one of eight boolean functions of them, and writes the result into one chosen bit. A field move copies one 4-bit field of the register onto another field. A whole-register load port lets the surrounding pipeline overwrite the register in one cycle, for example when it restores state. The current contents are always visible on the output.

Bits are numbered from the most significant end: index 0 is output bit 31 and index 31 is output bit 0. Each clock the block picks one action: ACT_LOAD when the load strobe is high, otherwise ACT_BIT, ACT_MOVE or ACT_NOP from the operation select when valid is high, and ACT_HOLD when neither strobe is high. The action picks the next register value. Reset overrides all actions. Each action leads back to the same choice on the next clock, so there is no multi-cycle sequence. Every operation reads the register as it was before the edge, so a target that overlaps a source sees the old value.

Top module: `cr_logic_unit`

## Requirements
- R1: A synchronous reset clears the register, so cr_q reads 0 after the reset edge. Reset overrides load and every operation.
- R2: When load_en is high at a clock edge, cr_q takes load_val on that edge, whatever op_valid and op_sel hold.
- R3: With load_en and op_valid both low, cr_q keeps its value across the edge, whatever the other inputs hold.
- R4: Bit index i (0..31) on idx_t, idx_a and idx_b refers to cr_q[31-i], so index 0 is the most significant bit.
- R5: op_sel values 0..7 choose the bit function of source a (bit idx_a) and source b (bit idx_b): 0 a&b, 1 ~(a&b), 2 a|b, 3 a^b, 4 ~(a|b), 5 ~(a^b), 6 a&~b, 7 a|~b. The result is written to bit idx_t.
- R6: A bit operation changes only bit idx_t. All other 31 bits keep their values.
- R7: op_sel 8 copies field fld_src to field fld_dst. Field k holds indices 4k..4k+3, which is cr_q[31-4k -: 4]. No other field changes.
- R8: Sources are read from the value before the edge. If idx_t equals idx_a or idx_b, the old value is used, and a move of a field onto itself leaves the register unchanged.
- R9: op_sel values 9..15 with op_valid high leave cr_q unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Perform the operation in op_sel on this edge |
| op_sel | input | 4 | Operation code (0..7 bit functions, 8 field move, 9..15 none) |
| idx_t | input | 5 | Target bit index, MSB-first |
| idx_a | input | 5 | First source bit index, MSB-first |
| idx_b | input | 5 | Second source bit index, MSB-first |
| fld_dst | input | 3 | Destination field index of the move |
| fld_src | input | 3 | Source field index of the move |
| load_en | input | 1 | Overwrite the whole register with load_val |
| load_val | input | 32 | Value for the full-register load |
| cr_q | output | 32 | Current register contents |

## Verification
Two things can happen in the same cycle: the whole-register load and a valid bit operation or field move. The bench drives load_en and op_valid together, with operands that would change the register, and expects cr_q to equal load_val alone on the next cycle. The other overlap lies inside one operation, where the target bit is also a source or a field is moved onto itself. The bench judges these against a reference model that reads only the value from before the edge.

// File: rtl/crlu_pkg.sv
package crlu_pkg;

    // Boolean function selected by the low three bits of the operation code
    typedef enum logic [2:0] {
        BOP_AND  = 3'd0,
        BOP_NAND = 3'd1,
        BOP_OR   = 3'd2,
        BOP_XOR  = 3'd3,
        BOP_NOR  = 3'd4,
        BOP_EQV  = 3'd5,
        BOP_ANDC = 3'd6,
        BOP_ORC  = 3'd7
    } bit_op_e;

    // Operation code of the field move; codes above it do nothing
    localparam logic [3:0] OPC_MOVE = 4'd8;

    // Update chosen for the current cycle
    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_LOAD = 3'd1,
        ACT_BIT  = 3'd2,
        ACT_MOVE = 3'd3,
        ACT_NOP  = 3'd4
    } act_e;

endpackage

// File: rtl/crlu_bool_unit.sv
module crlu_bool_unit
    import crlu_pkg::*;
(
    input  logic    a,
    input  logic    b,
    input  bit_op_e fn,
    output logic    y
);

    always_comb begin
        unique case (fn)
            BOP_AND:  y = a & b;
            BOP_NAND: y = ~(a & b);
            BOP_OR:   y = a | b;
            BOP_XOR:  y = a ^ b;
            BOP_NOR:  y = ~(a | b);
            BOP_EQV:  y = ~(a ^ b);
            BOP_ANDC: y = a & ~b;
            BOP_ORC:  y = a | ~b;
            default:  y = 1'b0;
        endcase
    end

endmodule

// File: rtl/crlu_bit_writer.sv
module crlu_bit_writer
    import crlu_pkg::*;
#(
    parameter int W = 32,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     cur,
    input  logic [IDX_W-1:0] idx_t,
    input  logic [IDX_W-1:0] idx_a,
    input  logic [IDX_W-1:0] idx_b,
    input  bit_op_e          fn,
    output logic [W-1:0]     nxt
);

    localparam logic [IDX_W-1:0] TOP = IDX_W'(W - 1);

    // Indices count from the most significant end
    logic [IDX_W-1:0] phys_t, phys_a, phys_b;
    logic             src_a, src_b, res;

    assign phys_t = TOP - idx_t;
    assign phys_a = TOP - idx_a;
    assign phys_b = TOP - idx_b;
    assign src_a  = cur[phys_a];
    assign src_b  = cur[phys_b];

    crlu_bool_unit u_bool (
        .a  (src_a),
        .b  (src_b),
        .fn (fn),
        .y  (res)
    );

    for (genvar j = 0; j < W; j++) begin : g_bit
        assign nxt[j] = (phys_t == IDX_W'(j)) ? res : cur[j];
    end

endmodule

// File: rtl/crlu_field_mover.sv
module crlu_field_mover #(
    parameter int W  = 32,
    parameter int FW = 4,
    localparam int NF   = W / FW,
    localparam int FI_W = $clog2(NF)
) (
    input  logic [W-1:0]    cur,
    input  logic [FI_W-1:0] dst,
    input  logic [FI_W-1:0] src,
    output logic [W-1:0]    nxt
);

    logic [FW-1:0] fld [NF];

    // Field k starts at the k-th nibble from the most significant end
    for (genvar k = 0; k < NF; k++) begin : g_fld
        assign fld[k] = cur[W-1-FW*k -: FW];
        assign nxt[W-1-FW*k -: FW] = (dst == FI_W'(k)) ? fld[src] : fld[k];
    end

endmodule

// File: rtl/cr_logic_unit.sv
module cr_logic_unit
    import crlu_pkg::*;
#(
    parameter int CR_W  = 32,
    parameter int FLD_W = 4,
    localparam int IDX_W = $clog2(CR_W),
    localparam int FI_W  = $clog2(CR_W / FLD_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [3:0]       op_sel,
    input  logic [IDX_W-1:0] idx_t,
    input  logic [IDX_W-1:0] idx_a,
    input  logic [IDX_W-1:0] idx_b,
    input  logic [FI_W-1:0]  fld_dst,
    input  logic [FI_W-1:0]  fld_src,
    input  logic             load_en,
    input  logic [CR_W-1:0]  load_val,
    output logic [CR_W-1:0]  cr_q
);

    logic [CR_W-1:0] cr_r, cr_nxt, bit_nxt, mv_nxt;
    act_e            act;

    crlu_bit_writer #(.W(CR_W)) u_bitw (
        .cur   (cr_r),
        .idx_t (idx_t),
        .idx_a (idx_a),
        .idx_b (idx_b),
        .fn    (bit_op_e'(op_sel[2:0])),
        .nxt   (bit_nxt)
    );

    crlu_field_mover #(.W(CR_W), .FW(FLD_W)) u_move (
        .cur (cr_r),
        .dst (fld_dst),
        .src (fld_src),
        .nxt (mv_nxt)
    );

    // Choose this cycle's action; a load wins over any operation
    always_comb begin
        act = ACT_HOLD;
        if (load_en)
            act = ACT_LOAD;
        else if (op_valid) begin
            if (!op_sel[3])
                act = ACT_BIT;
            else if (op_sel == OPC_MOVE)
                act = ACT_MOVE;
            else
                act = ACT_NOP;
        end
    end

    always_comb begin
        unique case (act)
            ACT_LOAD: cr_nxt = load_val;
            ACT_BIT:  cr_nxt = bit_nxt;
            ACT_MOVE: cr_nxt = mv_nxt;
            default:  cr_nxt = cr_r;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cr_r <= '0;
        else
            cr_r <= cr_nxt;
    end

    assign cr_q = cr_r;

    // R1: reset clears the register
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cr_q == '0));

    // R2: load takes the port value regardless of any operation
    p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (cr_q == $past(load_val)));

    // R3: no strobe, no change
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !op_valid) |=> $stable(cr_q));

    // R6: a bit operation flips at most one bit
    p_single_bit_r6: assert property (@(posedge clk) disable iff (rst)
        (!load_en && op_valid && !op_sel[3]) |=>
            ($countones(cr_q ^ $past(cr_q)) <= 1));

    // R7: a field move touches at most one field's worth of bits
    p_move_width_r7: assert property (@(posedge clk) disable iff (rst)
        (!load_en && op_valid && op_sel == OPC_MOVE) |=>
            ($countones(cr_q ^ $past(cr_q)) <= FLD_W));

    // R8: moving a field onto itself changes nothing
    p_self_move_r8: assert property (@(posedge clk) disable iff (rst)
        (!load_en && op_valid && op_sel == OPC_MOVE && fld_dst == fld_src) |=>
            $stable(cr_q));

    // R9: unused codes leave the register alone
    p_unused_code_r9: assert property (@(posedge clk) disable iff (rst)
        (!load_en && op_valid && op_sel > OPC_MOVE) |=> $stable(cr_q));

endmodule

// File: tb/test_cr_logic_unit.sv
module test_cr_logic_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [4:0]  idx_t = '0, idx_a = '0, idx_b = '0;
    logic [2:0]  fld_dst = '0, fld_src = '0;
    logic        load_en = 1'b0;
    logic [31:0] load_val = '0;
    logic [31:0] cr_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    // Reference register, element 0 is the most significant bit
    logic [0:31] mreg = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cr_logic_unit i_cr_logic_unit (
        .clk, .rst, .op_valid, .op_sel, .idx_t, .idx_a, .idx_b,
        .fld_dst, .fld_src, .load_en, .load_val, .cr_q
    );

    function automatic logic bfun(input int code, input logic a, input logic b);
        case (code)
            0: return a & b;
            1: return !(a & b);
            2: return a | b;
            3: return a != b;
            4: return !(a | b);
            5: return a == b;
            6: return a & !b;
            default: return a | !b;
        endcase
    endfunction

    // Monitor: compare each queued expectation away from the clock edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (cr_q !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%08h expected=%08h", it.tag, cr_q, it.exp);
            end
        end
    end

    // Driver: apply one cycle of stimulus, update the model, queue the result
    task automatic drive(input logic r, input logic ld, input logic [31:0] lv,
                         input logic v, input int op, input int t, input int a,
                         input int b, input int fd, input int fs, input string tag);
        logic [0:31] old;
        logic [31:0] e;
        @(negedge clk);
        rst = r; load_en = ld; load_val = lv; op_valid = v;
        op_sel = 4'(op); idx_t = 5'(t); idx_a = 5'(a); idx_b = 5'(b);
        fld_dst = 3'(fd); fld_src = 3'(fs);
        old = mreg;
        if (r) mreg = '0;
        else if (ld) mreg = lv;
        else if (v && op < 8) mreg[t] = bfun(op, old[a], old[b]);
        else if (v && op == 8) mreg[4*fd +: 4] = old[4*fs +: 4];
        @(posedge clk);
        #1;
        e = mreg;
        sbq.push_back('{exp: e, tag: tag});
    endtask

    task automatic load(input logic [31:0] v, input string tag);
        drive(1'b0, 1'b1, v, 1'b0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic bop(input int op, input int t, input int a, input int b, input string tag);
        drive(1'b0, 1'b0, 32'h0, 1'b1, op, t, a, b, 0, 0, tag);
    endtask

    task automatic fmove(input int fd, input int fs, input string tag);
        drive(1'b0, 1'b0, 32'h0, 1'b1, 8, 0, 0, 0, fd, fs, tag);
    endtask

    initial begin
        // R1: reset state
        drive(1'b1, 1'b0, 32'h0, 1'b0, 0, 0, 0, 0, 0, 0, "R1");
        drive(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 7, 3, 3, 3, 0, 0, "R1");

        // R2: plain load
        load(32'h1234_5678, "R2");

        // R3: idle with busy-looking inputs
        drive(1'b0, 1'b0, 32'hDEAD_BEEF, 1'b0, 7, 0, 1, 2, 3, 4, "R3");
        drive(1'b0, 1'b0, 32'h0, 1'b0, 8, 5, 5, 5, 0, 7, "R3");

        // R4: index 0 is the MSB, index 31 the LSB (orc a,a gives 1)
        load(32'h0, "R4");
        bop(7, 0, 5, 5, "R4");
        bop(7, 31, 9, 9, "R4");
        bop(1, 16, 2, 2, "R4");

        // R5: each function over every source pair and both target preloads
        for (int op = 0; op < 8; op++) begin
            for (int ab = 0; ab < 4; ab++) begin
                for (int tp = 0; tp < 2; tp++) begin
                    logic [0:31] lv;
                    lv = '0;
                    lv[3] = ab[1];
                    lv[10] = ab[0];
                    lv[20] = tp[0];
                    load(lv, "R5");
                    bop(op, 20, 3, 10, "R5");
                end
            end
        end

        // R6: single-bit writes into dense backgrounds
        load(32'hA5A5_A5A5, "R6");
        bop(3, 7, 0, 1, "R6");
        bop(4, 12, 31, 30, "R6");
        load(32'hFFFF_FFFF, "R6");
        bop(6, 25, 2, 4, "R6");
        load(32'h0000_0000, "R6");
        bop(5, 30, 1, 8, "R6");

        // R7: field moves including the end fields
        load(32'h0123_4567, "R7");
        fmove(7, 0, "R7");
        fmove(0, 6, "R7");
        fmove(3, 5, "R7");

        // R8: overlap of target and source, self move
        load(32'h8000_0001, "R8");
        bop(3, 0, 0, 31, "R8");
        bop(2, 31, 0, 31, "R8");
        bop(1, 15, 15, 15, "R8");
        load(32'h9ABC_DEF0, "R8");
        fmove(4, 4, "R8");

        // R9: unused codes with operands that would otherwise change bits
        load(32'h3C3C_3C3C, "R9");
        for (int op = 9; op < 16; op++)
            drive(1'b0, 1'b0, 32'h0, 1'b1, op, 0, 1, 2, 0, 7, "R9");

        // R2: load and operation in the same cycle
        load(32'h0000_0000, "R2");
        drive(1'b0, 1'b1, 32'h5555_AAAA, 1'b1, 7, 0, 4, 4, 0, 0, "R2");
        drive(1'b0, 1'b1, 32'h0F0F_0F0F, 1'b1, 8, 0, 0, 0, 2, 5, "R2");

        // R1: reset over load and operation
        drive(1'b1, 1'b1, 32'hFFFF_0000, 1'b1, 8, 0, 0, 0, 1, 2, "R1");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule